// File: doc/BRIEF.md
# Punctured Rate-1/2 Convolutional Encoder

This block is the channel encoder at the front of a spread-spectrum transmit chain. Information bits enter one at a time through a valid/ready handshake. Each bit goes through a nonsystematic convolutional code with constraint length 3 and two generator taps, 101 and 111 in binary (5 and 7 in octal). Some of the resulting coded bits are then deleted by a puncturing pattern, so the link can run at code rate 1/2, 2/3, 3/4 or 4/5 from the same mother code. The surviving bits leave serially through a second valid/ready handshake.

A frame-start pulse clears the encoder memory and restarts the puncturing phase. On that pulse the block also latches the rate selection and the tail option. When the tail option is on, the input bit that is flagged as last is followed by two internally generated zero bits. These drive the trellis back to the all-zero state, and the same puncturing pattern applies to them. The encoder accepts a new information bit only after every coded bit of the previous one has left.

Top module: `punc_conv_enc`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, the encoder memory is zero, the latched rate is 1/2 and the tail option is off.
- R2: For an accepted bit b, with d1 the previous bit and d2 the one before it, the first coded bit is b^d2 and the second is b^d1^d2. The first is emitted before the second.
- R3: rate_sel_i encodes 0=1/2, 1=2/3, 2=3/4, 3=4/5. At phase p, the first coded bit is kept when bit p of row A is 1, and the second when bit p of row B is 1. The rows, written from phase 0 upward, are: 2/3 A=10 B=11; 3/4 A=101 B=110; 4/5 A=1000 B=1111. At rate 1/2 every bit is kept.
- R4: The puncturing phase starts at 0 on frame start. It advances by one for every encoded bit, tail bits included, and wraps at the period (1, 2, 3 or 4 for the four rates).
- R5: The kept bits of one encoded bit appear on consecutive output beats. A deleted position leaves no gap, and out_valid_o rises in the cycle after the bit is taken.
- R6: in_ready_o is 0 while coded bits are still pending, while tail bits remain, or while frame_start_i is 1. No input is taken unless in_valid_i and in_ready_o are both 1.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o and out_bit_o hold their values into the next cycle.
- R8: frame_start_i clears the encoder memory, the phase, any pending output and any pending tail. It latches rate_sel_i and tail_en_i. rate_sel_i has no effect at any other time.
- R9: With the tail option latched on, taking a bit with in_last_i=1 makes the block encode two zero bits after it. These are punctured as normal, and in_ready_o stays 0 until their kept bits have left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start_i | input | 1 | One-cycle frame start; clears state, latches rate and tail option |
| rate_sel_i | input | 2 | Code rate code, sampled on frame start |
| tail_en_i | input | 1 | Tail option, sampled on frame start |
| in_valid_i | input | 1 | Information bit valid |
| in_bit_i | input | 1 | Information bit |
| in_last_i | input | 1 | Marks the last information bit of the frame |
| in_ready_o | output | 1 | Encoder can take an information bit |
| out_valid_o | output | 1 | Coded bit valid |
| out_bit_o | output | 1 | Coded bit |
| out_ready_i | input | 1 | Consumer takes the coded bit |

## Verification
The assertions assume the following about the inputs. frame_start_i is a single-cycle pulse. in_last_i is only meaningful together with an accepted bit. The consumer may stall for any number of cycles. The stimulus issues each frame start as a one-cycle pulse. It changes rate_sel_i away from the latched value in the middle of frames. It inserts random gaps on the input side and random stalls on the output side. It waits for the in_ready_o handshake before dropping in_valid_i, so a bit is never offered and then withdrawn.

// File: rtl/pce_pkg.sv
// Shared types and pattern helpers for the punctured convolutional encoder.
// Assumes the mother code has exactly two outputs per information bit.
package pce_pkg;

    typedef enum logic [1:0] {
        RATE_1_2 = 2'd0,
        RATE_2_3 = 2'd1,
        RATE_3_4 = 2'd2,
        RATE_4_5 = 2'd3
    } pce_rate_e;

    localparam int PH_W     = 2;
    localparam int NUM_OUTS = 2;

    // Number of information bits in one puncturing cycle.
    function automatic logic [PH_W:0] pce_period(input pce_rate_e r);
        case (r)
            RATE_2_3: return 3'd2;
            RATE_3_4: return 3'd3;
            RATE_4_5: return 3'd4;
            default:  return 3'd1;
        endcase
    endfunction

    // Keep mask at a phase: bit 0 = first output, bit 1 = second output.
    function automatic logic [NUM_OUTS-1:0] pce_keep(input pce_rate_e r,
                                                     input logic [PH_W-1:0] ph);
        logic [3:0] row_a;
        logic [3:0] row_b;
        case (r)
            RATE_2_3: begin row_a = 4'b0001; row_b = 4'b0011; end
            RATE_3_4: begin row_a = 4'b0101; row_b = 4'b0011; end
            RATE_4_5: begin row_a = 4'b0001; row_b = 4'b1111; end
            default:  begin row_a = 4'b1111; row_b = 4'b1111; end
        endcase
        return {row_b[ph], row_a[ph]};
    endfunction

endpackage

// File: rtl/pce_trellis.sv
// Shift register and generator taps of the mother code.
// Produces both coded bits combinationally from the current input and the
// stored history; the history shifts only when adv_i is high.
// Assumes CLEN >= 3.
module pce_trellis #(
    parameter int               CLEN   = 3,
    parameter logic [CLEN-1:0]  POLY_A = 3'b101,
    parameter logic [CLEN-1:0]  POLY_B = 3'b111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       adv_i,
    input  logic       bit_i,
    output logic [1:0] code_o
);

    localparam int MEM = CLEN - 1;

    // sr[MEM-1] is the most recent past bit, sr[0] the oldest.
    logic [MEM-1:0]  sr;
    logic [CLEN-1:0] win;

    assign win = {bit_i, sr};

    // Memory update: clear on reset or frame start, shift on each encoded bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sr <= '0;
        end else if (adv_i) begin
            sr <= {bit_i, sr[MEM-1:1]};
        end
    end

    // One parity tree per generator.
    for (genvar g = 0; g < 2; g++) begin : g_gen
        localparam logic [CLEN-1:0] POLY = (g == 0) ? POLY_A : POLY_B;
        always_comb code_o[g] = ^(win & POLY);
    end

    // R8: a frame start leaves the memory empty in the next cycle.
    a_r8_mem_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sr == '0));

endmodule

// File: rtl/pce_puncture.sv
// Puncturing phase counter and latched rate selection.
// The rate is captured only when clr_i (frame start) is high.
module pce_puncture
    import pce_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  pce_rate_e       rate_i,
    input  logic            adv_i,
    output logic [1:0]      keep_o
);

    pce_rate_e          rate_q;
    logic [PH_W-1:0]    phase_q;
    logic [PH_W:0]      period;
    logic [PH_W:0]      phase_nx;

    assign period   = pce_period(rate_q);
    assign phase_nx = {1'b0, phase_q} + 1'b1;
    assign keep_o   = pce_keep(rate_q, phase_q);

    // Phase and rate: restart on frame start, step and wrap on each encoded bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= RATE_1_2;
            phase_q <= '0;
        end else if (clr_i) begin
            rate_q  <= rate_i;
            phase_q <= '0;
        end else if (adv_i) begin
            phase_q <= (phase_nx == period) ? '0 : phase_nx[PH_W-1:0];
        end
    end

    // R4: the phase never reaches the period of the latched rate.
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, phase_q} < period));

    // R4: the phase restarts at zero after a frame start.
    a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (phase_q == '0));

    // R3: no pattern position deletes both coded bits.
    a_r3_keep_any: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (keep_o != 2'b00));

endmodule

// File: rtl/pce_outbuf.sv
// Two-entry serializer for the coded bits of one information bit.
// Loads only when empty; entry 0 is always presented first.
module pce_outbuf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       load_i,
    input  logic [1:0] code_i,
    input  logic [1:0] keep_i,
    output logic       empty_o,
    output logic       valid_o,
    output logic       bit_o,
    input  logic       ready_i
);

    logic [1:0] data_q;
    logic [1:0] cnt_q;

    assign empty_o = (cnt_q == 2'd0);
    assign valid_o = !empty_o;
    assign bit_o   = data_q[0];

    // Buffer update: drop on clear, pack kept bits on load, shift on a beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            case (keep_i)
                2'b11: begin data_q <= code_i;             cnt_q <= 2'd2; end
                2'b01: begin data_q <= {1'b0, code_i[0]};  cnt_q <= 2'd1; end
                2'b10: begin data_q <= {1'b0, code_i[1]};  cnt_q <= 2'd1; end
                default: begin data_q <= '0;               cnt_q <= 2'd0; end
            endcase
        end else if (valid_o && ready_i) begin
            data_q <= {1'b0, data_q[1]};
            cnt_q  <= cnt_q - 2'd1;
        end
    end

    // R7: a stalled beat holds its bit.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !clr_i) |=> (valid_o && $stable(bit_o)));

    // R5: loaded bits are offered in the next cycle.
    a_r5_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> valid_o);

    // R6: a load never overwrites bits that are still pending.
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> empty_o);

endmodule

// File: rtl/punc_conv_enc.sv
// Punctured rate-1/2 convolutional encoder, top level.
// Takes one information bit per handshake, encodes it with the (5,7) octal
// mother code, deletes bits per the latched puncturing pattern and streams
// the rest out serially. frame_start_i is assumed to be a one-cycle pulse.
module punc_conv_enc
    import pce_pkg::*;
#(
    parameter int CLEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start_i,
    input  logic [1:0] rate_sel_i,
    input  logic       tail_en_i,
    input  logic       in_valid_i,
    input  logic       in_bit_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic       out_valid_o,
    output logic       out_bit_o,
    input  logic       out_ready_i
);

    localparam int TAIL_LEN = CLEN - 1;
    localparam int TAIL_W   = $clog2(TAIL_LEN + 1);

    logic              tail_on_q;
    logic [TAIL_W-1:0] tail_cnt_q;
    logic              buf_empty;
    logic              take_in;
    logic              take_tail;
    logic              adv;
    logic              enc_bit;
    logic [1:0]        code;
    logic [1:0]        keep;

    assign in_ready_o = buf_empty && (tail_cnt_q == '0) && !frame_start_i;
    assign take_in    = in_valid_i && in_ready_o;
    assign take_tail  = buf_empty && (tail_cnt_q != '0) && !frame_start_i;
    assign adv        = take_in || take_tail;
    assign enc_bit    = take_in ? in_bit_i : 1'b0;

    // Tail option latch: captured on frame start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_on_q <= 1'b0;
        end else if (frame_start_i) begin
            tail_on_q <= tail_en_i;
        end
    end

    // Tail counter: armed by the last bit, counts down per injected zero.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start_i) begin
            tail_cnt_q <= '0;
        end else if (take_in && in_last_i && tail_on_q) begin
            tail_cnt_q <= TAIL_W'(TAIL_LEN);
        end else if (take_tail) begin
            tail_cnt_q <= tail_cnt_q - 1'b1;
        end
    end

    pce_trellis #(
        .CLEN   (CLEN),
        .POLY_A (CLEN'(5)),
        .POLY_B (CLEN'(7))
    ) u_trellis (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (frame_start_i),
        .adv_i  (adv),
        .bit_i  (enc_bit),
        .code_o (code)
    );

    pce_puncture u_punct (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (frame_start_i),
        .rate_i (pce_rate_e'(rate_sel_i)),
        .adv_i  (adv),
        .keep_o (keep)
    );

    pce_outbuf u_obuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (frame_start_i),
        .load_i  (adv),
        .code_i  (code),
        .keep_i  (keep),
        .empty_o (buf_empty),
        .valid_o (out_valid_o),
        .bit_o   (out_bit_o),
        .ready_i (out_ready_i)
    );

    // R6: input is never offered as ready while output is pending.
    a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !out_valid_o);

    // R9: pending tail bits block new input.
    a_r9_tail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_cnt_q != '0) |-> !in_ready_o);

    // R8: a frame start empties the output side.
    a_r8_out_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> !out_valid_o);

endmodule

// File: tb/punc_conv_enc_tb.sv
`timescale 1ns/1ps
module punc_conv_enc_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start_i = 1'b0;
    logic [1:0] rate_sel_i = 2'd0;
    logic tail_en_i = 1'b0;
    logic in_valid_i = 1'b0;
    logic in_bit_i = 1'b0;
    logic in_last_i = 1'b0;
    logic in_ready_o;
    logic out_valid_o;
    logic out_bit_o;
    logic out_ready_i = 1'b1;

    always #2.5 clk = ~clk;

    punc_conv_enc u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .rate_sel_i(rate_sel_i), .tail_en_i(tail_en_i),
        .in_valid_i(in_valid_i), .in_bit_i(in_bit_i), .in_last_i(in_last_i),
        .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
        .out_bit_o(out_bit_o), .out_ready_i(out_ready_i)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit stall_en = 0;
    bit finished = 0;

    // Behavioural reference state
    bit mq[$];
    bit col[$];
    int mtail = 0, mphase = 0, mrate = 0;
    bit mtail_on = 0, ms1 = 0, ms2 = 0;
    bit pv = 0, pr = 0, pb = 0, ps = 1;

    string rowa[4] = '{"1111", "10", "101", "1000"};
    string rowb[4] = '{"1111", "11", "110", "1111"};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_encode(input bit b);
        bit g5, g7;
        int per;
        g5 = b ^ ms2;
        g7 = b ^ ms1 ^ ms2;
        per = rowa[mrate].len();
        if (rowa[mrate][mphase] == "1") mq.push_back(g5);
        if (rowb[mrate][mphase] == "1") mq.push_back(g7);
        mphase = (mphase + 1) % per;
        ms2 = ms1;
        ms1 = b;
    endtask

    // Per-cycle compare and reference update, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(out_valid_o == (mq.size() != 0), "R5 out_valid", out_valid_o, mq.size() != 0);
            if (mq.size() != 0)
                check(out_bit_o == mq[0], "R2 out_bit", out_bit_o, mq[0]);
            check(in_ready_o == (mq.size() == 0 && mtail == 0 && !frame_start_i),
                  "R6 in_ready", in_ready_o, (mq.size() == 0 && mtail == 0 && !frame_start_i));
            if (pv && !pr && !ps)
                check(out_valid_o && out_bit_o == pb, "R7 hold", out_bit_o, pb);
        end
        pv = out_valid_o; pr = out_ready_i; pb = out_bit_o; ps = frame_start_i || !rst_n;
        if (!rst_n) begin
            mq.delete(); mtail = 0; mphase = 0; mrate = 0; mtail_on = 0; ms1 = 0; ms2 = 0;
        end else if (frame_start_i) begin
            mq.delete(); mtail = 0; mphase = 0; mrate = int'(rate_sel_i);
            mtail_on = tail_en_i; ms1 = 0; ms2 = 0;
        end else if (mq.size() != 0) begin
            if (out_ready_i) begin
                col.push_back(out_bit_o);
                void'(mq.pop_front());
            end
        end else if (mtail > 0) begin
            model_encode(1'b0);
            mtail--;
        end else if (in_valid_i) begin
            model_encode(in_bit_i);
            if (in_last_i && mtail_on) mtail = 2;
        end
        if (cyc > 150000 && !finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    // Output-side back-pressure driver.
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready_i = stall_en ? ($urandom % 4 != 0) : 1'b1;
        end
    end

    task automatic send_bit(input bit b, input bit last);
        bit taken;
        in_valid_i = 1'b1; in_bit_i = b; in_last_i = last;
        do begin
            @(negedge clk); taken = in_ready_o;
            @(posedge clk); #1;
        end while (!taken);
        in_valid_i = 1'b0; in_last_i = 1'b0;
    endtask

    task automatic start_frame(input logic [1:0] r, input bit t);
        rate_sel_i = r; tail_en_i = t; frame_start_i = 1'b1;
        @(posedge clk); #1;
        frame_start_i = 1'b0;
        rate_sel_i = ~r;
        tail_en_i = ~t;
        col.delete();
    endtask

    task automatic drain();
        do @(negedge clk); while (mq.size() != 0 || mtail != 0 || out_valid_o);
        @(posedge clk); #1;
    endtask

    task automatic send4(input bit last);
        send_bit(1, 0); send_bit(0, 0); send_bit(1, 0); send_bit(1, last);
    endtask

    task automatic expect_seq(input string tag, input string s);
        check(col.size() == s.len(), {tag, " length"}, col.size(), s.len());
        for (int i = 0; i < s.len() && i < col.size(); i++)
            check(col[i] == (s[i] == "1"), {tag, " bit"}, col[i], s[i] == "1");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid_o == 0, "R1 reset out_valid", out_valid_o, 0);
        check(in_ready_o == 1, "R1 reset in_ready", in_ready_o, 1);
        @(posedge clk); #1;

        // R1: no frame start yet, default rate 1/2 and zero memory.
        col.delete();
        send4(1); drain();
        expect_seq("R1 R2 default rate", "11010010");

        start_frame(2'd1, 0); send4(0); drain();
        expect_seq("R3 rate 2/3", "111000");
        start_frame(2'd2, 0); send4(0); drain();
        expect_seq("R3 rate 3/4", "111010");
        start_frame(2'd3, 0); send4(0); drain();
        expect_seq("R3 rate 4/5", "11100");

        // R4: phase keeps running across bits: 6 bits at 2/3 give 9 outputs.
        start_frame(2'd1, 0);
        for (int i = 0; i < 6; i++) send_bit(i[0], 0);
        drain();
        check(col.size() == 9, "R4 phase count", col.size(), 9);

        // R9: tail at rate 1/2 and at rate 4/5.
        start_frame(2'd0, 1); send4(1); drain();
        expect_seq("R9 tail 1/2", "110100101011");
        start_frame(2'd3, 1); send4(1); drain();
        expect_seq("R9 tail 4/5", "11100101");

        // R8: frame start clears memory; mid-frame rate_sel_i is ignored.
        start_frame(2'd0, 0); send_bit(1, 0); send_bit(1, 0); drain();
        start_frame(2'd0, 0); rate_sel_i = 2'd3;
        send_bit(1, 0); send_bit(0, 0); drain();
        expect_seq("R8 clear and rate hold", "1101");

        // R8: frame start drops pending output.
        stall_en = 0;
        start_frame(2'd0, 1); send_bit(1, 1);
        start_frame(2'd0, 0);
        @(negedge clk);
        check(out_valid_o == 0, "R8 pending dropped", out_valid_o, 0);
        @(posedge clk); #1;

        // R5 R6 R7: random frames with stalls, checked every cycle by the model.
        stall_en = 1;
        for (int f = 0; f < 40; f++) begin
            int len;
            len = 1 + ($urandom % 12);
            start_frame(2'($urandom % 4), 1'($urandom % 2));
            for (int i = 0; i < len; i++) begin
                if ($urandom % 3 == 0) begin @(posedge clk); #1; end
                send_bit(1'($urandom % 2), i == len - 1);
            end
            drain();
        end
        stall_en = 0;
        repeat (4) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule